// File: doc/BRIEF.md
# HDLC Receive Bit Deframer

This block turns a serial HDLC bit stream into bytes for a parallel backend. It runs entirely on the receive clock. A bit-enable input marks the cycles that carry a new line bit. The block starts in a hunting state and opens a frame on the first flag it sees. Inside a frame it removes the zeros that the transmitter stuffed into the stream. It assembles the remaining bits into bytes, least significant bit first, and delivers them one byte per strobe, with markers for the first and the last byte of each frame.

A closing flag ends the frame. A frame whose length is not a whole number of bytes ends with a zero-padded byte and a count of the valid bits in that byte. A run of seven ones inside a frame aborts the frame. The abort is reported as a final strobe carrying an abort marker, and the block then ignores the line until a new flag arrives. A longer run of ones raises a line-idle level. CRC checking, address matching and buffering belong to the surrounding logic.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame, every output is low.
- R2: Before the first flag, line bits produce no output. The pattern 0,1,1,1,1,1,1,0 (six ones framed by zeros) opens a frame.
- R3: Inside a frame, a zero that follows exactly five consecutive ones is removed from the data.
- R4: Data bits are packed into bytes with the first received bit in bit 0. Each byte is delivered with a single-cycle oct_valid. oct_first is set on the first byte of a frame and clear on every later byte.
- R5: A flag inside a frame ends it, and oct_last marks the frame's final byte. The same flag also opens the next frame. Consecutive flags, and frames with no data bits, produce no output.
- R6: When a frame's bit count is not a multiple of 8, its final byte carries the leftover bits in its low positions, with zeros above them. oct_tail then gives the number of valid bits (1 to 7). oct_tail is 0 on every other byte, which means all 8 bits are valid.
- R7: Seven consecutive ones inside an open frame end it with a single strobe that has oct_valid, oct_last and oct_abort set, oct_data 0 and oct_tail 0. oct_first is also set if no byte of that frame was delivered. Bits of the frame that were not yet delivered are discarded.
- R8: After an abort, line bits produce no output until a new flag opens a frame.
- R9: line_idle rises at the clock edge that samples the fifteenth consecutive one. It stays high while ones continue and falls at the edge that samples a zero.
- R10: A line bit is taken only on a clock edge where bit_en is high. An output caused by a bit is visible right after the edge that samples that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Receive clock |
| rst_rx_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| bit_in | input | 1 | Serial line bit |
| oct_valid | output | 1 | One-cycle strobe for a delivered byte or an abort |
| oct_data | output | 8 | Byte value, with the first received bit in bit 0 |
| oct_first | output | 1 | First byte of a frame |
| oct_last | output | 1 | Final byte of a frame, or abort |
| oct_abort | output | 1 | Frame ended by an abort |
| oct_tail | output | 3 | Valid bits in the final byte, with 0 meaning 8 |
| line_idle | output | 1 | Long all-ones run on the line |

## Verification
Two functions meet in one cycle when a single flag closes one frame and opens the next. On that sample the block must deliver the final byte of the old frame, padded if it is partial, and at the same time reset its assembly state for the new frame. The bench provokes this by sending back-to-back frames that share one flag, with the second frame containing a stuffed zero and a partial final byte. A scoreboard then requires the old frame's byte with oct_last set, followed by the new frame's byte with oct_first set and the correct value and tail count.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    // Run lengths of ones that give the line its meaning.
    localparam int FLAG_RUN  = 6;
    localparam int STUFF_RUN = FLAG_RUN - 1;
    localparam int ABORT_RUN = FLAG_RUN + 1;
    // Bits held back before they can be trusted as data.
    localparam int HOLD_BITS = FLAG_RUN + 1;

    // Events passed from the line stage to the byte stage.
    typedef struct packed {
        logic push_vld;
        logic push_bit;
        logic close;
        logic abort;
    } lane_ev_t;

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_RUN = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  logic     bit_in,
    output lane_ev_t ev,
    output logic     idle
);

    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam int PCW   = $clog2(HOLD_BITS + 1);

    typedef struct packed {
        logic [RUN_W-1:0]     ones;
        logic                 in_frame;
        logic                 idle;
        logic [HOLD_BITS-1:0] pend;
        logic [PCW-1:0]       pcnt;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     push;

    always_comb begin
        st_d = st_q;
        ev   = '0;
        push = 1'b0;
        if (bit_en) begin
            if (bit_in) begin
                if (st_q.ones != RUN_W'(IDLE_RUN)) begin
                    st_d.ones = st_q.ones + 1'b1;
                end
                if (st_d.ones == RUN_W'(ABORT_RUN) && st_q.in_frame) begin
                    ev.abort      = 1'b1;
                    st_d.in_frame = 1'b0;
                    st_d.pcnt     = '0;
                end else if (st_q.in_frame) begin
                    push = 1'b1;
                end
                if (st_d.ones == RUN_W'(IDLE_RUN)) begin
                    st_d.idle = 1'b1;
                end
            end else begin
                st_d.ones = '0;
                st_d.idle = 1'b0;
                if (st_q.ones == RUN_W'(FLAG_RUN)) begin
                    ev.close      = st_q.in_frame;
                    st_d.in_frame = 1'b1;
                    st_d.pcnt     = '0;
                end else if (st_q.in_frame && st_q.ones != RUN_W'(STUFF_RUN)) begin
                    push = 1'b1;
                end
            end
        end
        if (push) begin
            st_d.pend = {bit_in, st_q.pend[HOLD_BITS-1:1]};
            if (st_q.pcnt == PCW'(HOLD_BITS)) begin
                ev.push_vld = 1'b1;
                ev.push_bit = st_q.pend[0];
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = st_q.idle;

    // R2: a frame can only open on a sampled zero
    a_r2_open_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.in_frame) |-> ($past(bit_en) && !$past(bit_in)));

    // R8: an abort leaves the frame
    a_r8_abort_exits: assert property (@(posedge clk) disable iff (!rst_n)
        ev.abort |=> !st_q.in_frame);

    // R9: idle never coexists with an open frame
    a_r9_idle_hunting: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idle |-> !st_q.in_frame);

endmodule

// File: rtl/hdlc_rx_octet.sv
module hdlc_rx_octet
    import hdlc_rx_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  lane_ev_t                 ev,
    output logic                     o_valid,
    output logic [OCT_W-1:0]         o_data,
    output logic                     o_first,
    output logic                     o_last,
    output logic                     o_abort,
    output logic [$clog2(OCT_W)-1:0] o_tail
);

    localparam int TW = $clog2(OCT_W);

    typedef struct packed {
        logic [OCT_W-1:0] sr;
        logic [TW-1:0]    bc;
        logic [OCT_W-1:0] hold;
        logic             hold_vld;
        logic             hold_first;
        logic             sent_any;
        logic             valid;
        logic             first;
        logic             last;
        logic             abort;
        logic [TW-1:0]    tail;
        logic [OCT_W-1:0] data;
    } oct_st_t;

    oct_st_t          st_d, st_q;
    logic [OCT_W-1:0] nsr;
    logic [TW:0]      sh;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.first = 1'b0;
        st_d.last  = 1'b0;
        st_d.abort = 1'b0;
        st_d.tail  = '0;
        st_d.data  = '0;
        nsr        = {ev.push_bit, st_q.sr[OCT_W-1:1]};
        sh         = (TW+1)'(OCT_W) - {1'b0, st_q.bc};
        if (ev.abort) begin
            st_d.valid    = 1'b1;
            st_d.last     = 1'b1;
            st_d.abort    = 1'b1;
            st_d.first    = !st_q.sent_any;
            st_d.bc       = '0;
            st_d.hold_vld = 1'b0;
            st_d.sent_any = 1'b0;
        end else if (ev.close) begin
            if (st_q.hold_vld) begin
                st_d.valid = 1'b1;
                st_d.last  = 1'b1;
                st_d.first = st_q.hold_first;
                st_d.data  = st_q.hold;
            end else if (st_q.bc != '0) begin
                st_d.valid = 1'b1;
                st_d.last  = 1'b1;
                st_d.first = !st_q.sent_any;
                st_d.tail  = st_q.bc;
                st_d.data  = st_q.sr >> sh;
            end
            st_d.bc       = '0;
            st_d.hold_vld = 1'b0;
            st_d.sent_any = 1'b0;
        end else if (ev.push_vld) begin
            if (st_q.hold_vld) begin
                st_d.valid    = 1'b1;
                st_d.first    = st_q.hold_first;
                st_d.data     = st_q.hold;
                st_d.hold_vld = 1'b0;
                st_d.sent_any = 1'b1;
            end
            st_d.sr = nsr;
            if (st_q.bc == TW'(OCT_W - 1)) begin
                st_d.hold       = nsr;
                st_d.hold_vld   = 1'b1;
                st_d.hold_first = !st_d.sent_any;
                st_d.bc         = '0;
            end else begin
                st_d.bc = st_q.bc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.valid;
    assign o_data  = st_q.data;
    assign o_first = st_q.first;
    assign o_last  = st_q.last;
    assign o_abort = st_q.abort;
    assign o_tail  = st_q.tail;

    // R7: an abort is a final, empty strobe
    a_r7_abort_shape: assert property (@(posedge clk) disable iff (!rst_n)
        o_abort |-> (o_valid && o_last && o_data == '0 && o_tail == '0));

    // R6: a tail count only accompanies the final byte
    a_r6_tail_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_last) |-> (o_tail == '0));

    // R6: padding above the valid bits is zero
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_last && !o_abort && o_tail != '0) |-> ((o_data >> o_tail) == '0));

    // R4: markers never appear without the strobe
    a_r4_marks_need_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> (!o_first && !o_last && !o_abort));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int OCT_W    = 8,
    parameter int IDLE_RUN = 15
) (
    input  logic                     clk_rx,
    input  logic                     rst_rx_n,
    input  logic                     bit_en,
    input  logic                     bit_in,
    output logic                     oct_valid,
    output logic [OCT_W-1:0]         oct_data,
    output logic                     oct_first,
    output logic                     oct_last,
    output logic                     oct_abort,
    output logic [$clog2(OCT_W)-1:0] oct_tail,
    output logic                     line_idle
);

    lane_ev_t lane_ev;

    hdlc_rx_line #(
        .IDLE_RUN (IDLE_RUN)
    ) i_line (
        .clk    (clk_rx),
        .rst_n  (rst_rx_n),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .ev     (lane_ev),
        .idle   (line_idle)
    );

    hdlc_rx_octet #(
        .OCT_W (OCT_W)
    ) i_octet (
        .clk     (clk_rx),
        .rst_n   (rst_rx_n),
        .ev      (lane_ev),
        .o_valid (oct_valid),
        .o_data  (oct_data),
        .o_first (oct_first),
        .o_last  (oct_last),
        .o_abort (oct_abort),
        .o_tail  (oct_tail)
    );

    // R9: an idle line delivers nothing
    a_r9_idle_quiet: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
        line_idle |-> !oct_valid);

    // R5: close and abort never come from one sample
    a_r5_single_end: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
        !(lane_ev.close && lane_ev.abort));

endmodule

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/100ps
module test_hdlc_rx_deframer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       oct_valid, oct_first, oct_last, oct_abort, line_idle;
    logic [7:0] oct_data;
    logic [2:0] oct_tail;

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int          ones_run = 0;
    logic [13:0] expq[$];

    always #2.5 clk = ~clk;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk_rx    (clk),
        .rst_rx_n  (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .oct_valid (oct_valid),
        .oct_data  (oct_data),
        .oct_first (oct_first),
        .oct_last  (oct_last),
        .oct_abort (oct_abort),
        .oct_tail  (oct_tail),
        .line_idle (line_idle)
    );

    function automatic logic [13:0] mk(input logic ab, input logic fi, input logic la,
                                       input logic [2:0] tl, input logic [7:0] dt);
        return {ab, fi, la, tl, dt};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design delivers.
    always @(negedge clk) begin
        logic [13:0] got;
        logic [13:0] exp;
        if (rst_n && oct_valid) begin
            got = {oct_abort, oct_first, oct_last, oct_tail, oct_data};
            if (expq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R5/R8 unexpected output: actual %0h expected none", got);
            end else begin
                exp = expq.pop_front();
                if (exp[13])            chk(got == exp, "R7", "abort strobe", got, exp);
                else if (exp[10:8] != 0) chk(got == exp, "R6", "padded byte", got, exp);
                else if (exp[11])       chk(got == exp, "R5", "final byte", got, exp);
                else                    chk(got == exp, "R4", "byte", got, exp);
            end
        end
    end

    // Driver tasks: all start and end at a falling edge.
    task automatic drive_bit(input logic b);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            bit_in = ~bit_in;
            @(negedge clk);
        end
    endtask

    task automatic raw_flag();
        drive_bit(1'b0);
        for (int i = 0; i < 6; i++) drive_bit(1'b1);
        drive_bit(1'b0);
        ones_run = 0;
    endtask

    task automatic data_bit(input logic b);
        drive_bit(b);
        if (b) begin
            ones_run++;
            if (ones_run == 5) begin
                drive_bit(1'b0);
                ones_run = 0;
            end
        end else begin
            ones_run = 0;
        end
    endtask

    // Sends up to two bytes plus tn tail bits; ends with a flag or an abort.
    task automatic send_frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                              input int tn, input logic [7:0] tv, input bit ab,
                              input int gp, input bit open_flag);
        logic [7:0] bt;
        int         nbits;
        int         em;
        nbits = n * 8 + tn;
        if (!ab) begin
            for (int i = 0; i < n; i++) begin
                bt = (i == 0) ? b0 : b1;
                expq.push_back(mk(1'b0, i == 0, (i == n - 1) && tn == 0, 3'd0, bt));
            end
            if (tn > 0)
                expq.push_back(mk(1'b0, n == 0, 1'b1, 3'(tn), tv & 8'((1 << tn) - 1)));
        end else begin
            // Data ends in a zero: all but the last bit are delivered before the abort.
            em = (nbits >= 2) ? (nbits - 2) / 8 : 0;
            for (int i = 0; i < em; i++) begin
                bt = (i == 0) ? b0 : b1;
                expq.push_back(mk(1'b0, i == 0, 1'b0, 3'd0, bt));
            end
            expq.push_back(mk(1'b1, em == 0, 1'b1, 3'd0, 8'd0));
        end
        if (open_flag) raw_flag();
        for (int i = 0; i < n; i++) begin
            bt = (i == 0) ? b0 : b1;
            for (int k = 0; k < 8; k++) begin
                data_bit(bt[k]);
                if (gp > 0) gap(gp);
            end
        end
        for (int k = 0; k < tn; k++) data_bit(tv[k]);
        if (ab) begin
            for (int i = 0; i < 7; i++) drive_bit(1'b1);
            ones_run = 0;
        end else begin
            raw_flag();
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] hunt_bits;
        // R1: reset with line activity
        @(negedge clk);
        bit_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            bit_in = ~bit_in;
            @(negedge clk);
        end
        bit_en = 1'b0;
        chk({oct_valid, oct_first, oct_last, oct_abort, oct_tail, oct_data, line_idle} == '0,
            "R1", "outputs in reset", oct_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({oct_valid, oct_first, oct_last, oct_abort, oct_tail, oct_data, line_idle} == '0,
            "R1", "outputs after reset", oct_valid, 0);

        // R2: bits before the first flag are ignored
        hunt_bits = 8'b0100_1101;
        for (int k = 0; k < 8; k++) drive_bit(hunt_bits[k]);

        // R4, R5: plain two-byte frame
        send_frame(2, 8'hA5, 8'h3C, 0, 8'h00, 1'b0, 0, 1'b1);

        // R3, R5, R6: frames sharing one flag, stuffing and a partial last byte
        send_frame(2, 8'hFF, 8'h7E, 0, 8'h00, 1'b0, 0, 1'b1);
        send_frame(1, 8'h1F, 8'h00, 5, 8'h16, 1'b0, 0, 1'b0);

        // R5: back-to-back flags give nothing
        raw_flag();
        raw_flag();

        // R6: frame of three bits only
        send_frame(0, 8'h00, 8'h00, 3, 8'h05, 1'b0, 0, 1'b0);

        // R7: abort after two delivered bytes and a partial one
        send_frame(2, 8'h12, 8'h34, 3, 8'h02, 1'b1, 0, 1'b1);

        // R8: no flag, so these bits are dropped
        hunt_bits = 8'b0011_1110;
        for (int k = 0; k < 8; k++) drive_bit(hunt_bits[k]);
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b0);

        // R9: idle detection
        drive_bit(1'b0);
        for (int i = 0; i < 14; i++) drive_bit(1'b1);
        chk(line_idle == 1'b0, "R9", "idle after 14 ones", line_idle, 0);
        drive_bit(1'b1);
        chk(line_idle == 1'b1, "R9", "idle after 15 ones", line_idle, 1);
        for (int i = 0; i < 3; i++) drive_bit(1'b1);
        chk(line_idle == 1'b1, "R9", "idle held", line_idle, 1);
        drive_bit(1'b0);
        chk(line_idle == 1'b0, "R9", "idle cleared by zero", line_idle, 0);

        // R7: abort right after the opening flag
        send_frame(0, 8'h00, 8'h00, 0, 8'h00, 1'b1, 0, 1'b1);

        // R10: gaps with a toggling line between real bits
        send_frame(2, 8'h81, 8'h7F, 0, 8'h00, 1'b0, 3, 1'b1);

        gap(20);
        chk(expq.size() == 0, "R5", "outstanding expected items", expq.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule